// File: doc/BRIEF.md
# Paging Codeword Receiver

This block takes a serial stream of 32-bit paging codewords, one bit per valid strobe. It finds the synchronization word and tracks where each codeword sits in the batch. Every codeword is checked against its BCH(31,21) check bits and repaired when it holds one or two bit errors. The repaired codeword goes out on a strobe so that an external matcher can compare addresses. Address fields and message information bits are loaded into holding registers.

Sticky event flags record:
- address arrivals
- message arrivals
- the start of data
- the end of data
- an uncorrectable codeword

Software clears these flags by writing ones to the clear port. A single interrupt output is the OR of the enabled sticky flags.

An uncorrectable codeword freezes the receiver until software pulses the restart input. The bit strobes must be at least 16 clock cycles apart, so that the repair search (at most 498 cycles) ends before the next codeword is complete.

Top module: `pgr_rx`

## Requirements
- R1: A codeword whose bits 31..1 hold zero, one or two bit errors (bit 31 is the type bit, bits 30..11 carry information, bits 10..1 are the check bits of the generator x^10+x^9+x^8+x^6+x^5+x^3+1, and bit 0 is even parity) is emitted once on `cw_o` with a one-cycle `cw_vld_o` pulse. The emitted value equals the error-free codeword, with bit 0 regenerated as even parity over bits 31..1.
- R2: A codeword that no pattern of two or fewer flips can repair:
  - sets `flags_o[4]`;
  - drops `msg_vld_o` to 0;
  - clears `flags_o[5]`;
  - produces no `cw_vld_o` pulse.

  From then on, every received bit is ignored, including a complete sync word, until `restart_i` is pulsed.
- R3: A one-cycle pulse on `restart_i` while frozen returns the block to sync search. A following sync word locks again, and the next codeword is decoded.
- R4: In search, `flags_o[5]` rises in the cycle after the last bit of the word 0x7CD215D8 arrives, at any bit alignment. The 16 codewords that follow form one batch, and the codeword in slot s (0..15) belongs to frame s/2. `flags_o` is 0 after reset.
- R5: The 32 bits that follow slot 15 must equal 0x7CD215D8 exactly, and then a new batch starts. Any other value clears `flags_o[5]`, and later codewords are not decoded until a new sync word is found.
- R6: The first address codeword of a reception (type bit 0, not the idle word 0x7A89C197) sets `flags_o[2]`.
- R7: Each address codeword sets `flags_o[0]`, pulses `addr_cw_o` with `cw_vld_o`, and loads `rx_addr_o` with {frame, bits 12..11}.
- R8: A message codeword (type bit 1) inside a reception loads bits 30..11 into `rx_msg_o`, sets `flags_o[1]` and sets `msg_vld_o`. A message codeword outside a reception still appears on `cw_o` but leaves `rx_msg_o` unchanged.
- R9: The idle word 0x7A89C197 received inside a reception sets `flags_o[3]` and ends the reception.
- R10: `flags_o[4:0]` stay set until a 1 is written to the same bit of `flag_clr_i`. Ones written to other bits leave them unchanged. `flag_clr_i[5]` has no effect.
- R11: `irq_o` is high exactly when some bit of `flags_o[4:0] & irq_en_i` is 1.
- R12: With bit strobes at least 16 cycles apart, every codeword of a batch yields exactly one `cw_vld_o` pulse, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit, most significant bit of each codeword first |
| bit_vld_i | input | 1 | One-cycle strobe marking bit_i valid |
| restart_i | input | 1 | Leave the frozen state and resume sync search |
| flag_clr_i | input | 6 | Write-one-to-clear mask for flags_o |
| irq_en_i | input | 5 | Interrupt enables for flags_o[4:0] |
| cw_o | output | 32 | Repaired codeword |
| cw_vld_o | output | 1 | cw_o valid, one cycle per codeword |
| addr_cw_o | output | 1 | cw_o is an address codeword |
| rx_addr_o | output | 5 | Frame number (bits 4..2) and function bits (1..0) of the last address |
| rx_msg_o | output | 20 | Last stored message information bits |
| msg_vld_o | output | 1 | rx_msg_o holds valid data |
| flags_o | output | 6 | {sync, error, end, begin, message, address} |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- **Repair at 0, 1 and 2 errors, including errors on the parity bit.** A search that stops early or flips the wrong position shows up as a miscompare on `cw_o`.
- **Three-error words the bench has shown to be outside every radius-2 repair.** These must freeze the receiver. A design that keeps running would emit codewords after a sync word that should have been ignored.
- **The batch-boundary sync check.** A wrong slot count either drops lock early or misses the broken sync slot.
- **A stray message codeword after the idle word.** A design that stores it overwrites `rx_msg_o`.
- **Clear and enable masks applied bit by bit.** These catch crossed flag positions and a clearable sync bit.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int CW_W   = 32;
  localparam int CHK_W  = 10;
  localparam logic [CHK_W-1:0] GEN_LOW = 10'h369;  // generator without x^10
  localparam logic [CW_W-1:0] SYNC_CW = 32'h7CD215D8;
  localparam logic [CW_W-1:0] IDLE_CW = 32'h7A89C197;

  localparam int FL_ADR  = 0;
  localparam int FL_MSG  = 1;
  localparam int FL_BEG  = 2;
  localparam int FL_END  = 3;
  localparam int FL_ERR  = 4;
  localparam int FL_SYNC = 5;
  localparam int NSTICKY = 5;
  localparam int NFLAG   = 6;

  typedef enum logic [1:0] {FR_HUNT, FR_LOCK, FR_HALT} fr_st_e;
  typedef enum logic [1:0] {FX_IDLE, FX_CHK, FX_ONE, FX_TWO} fx_st_e;

  // remainder of bits 31..1 times x^10; zero iff a valid BCH word
  function automatic logic [CHK_W-1:0] bch_syn(input logic [CW_W-1:0] w);
    logic [CHK_W-1:0] r;
    logic fb;
    r = '0;
    for (int k = CW_W-1; k >= 1; k--) begin
      fb = r[CHK_W-1] ^ w[k];
      r  = {r[CHK_W-2:0], 1'b0};
      if (fb) r = r ^ GEN_LOW;
    end
    return r;
  endfunction
endpackage

// File: rtl/pgr_bch_fix.sv
module pgr_bch_fix
  import pgr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CW_W-1:0] word_i,
  output logic            done_o,
  output logic            ok_o,
  output logic [CW_W-1:0] cw_o
);
  localparam int POS_W = $clog2(CW_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CW_W-1);
  localparam logic [POS_W-1:0] POS_PEN  = POS_W'(CW_W-2);

  fx_st_e          st_q;
  logic [CW_W-1:0] w_q, flip, cand, fixed_cw, cw_q;
  logic [POS_W-1:0] i_q, j_q;
  logic            hit, done_q, ok_q;

  always_comb begin
    flip = '0;
    if (st_q == FX_ONE) flip = CW_W'(1) << i_q;
    else if (st_q == FX_TWO) flip = (CW_W'(1) << i_q) | (CW_W'(1) << j_q);
  end

  assign cand     = w_q ^ flip;
  assign hit      = (bch_syn(cand) == '0);
  assign fixed_cw = {cand[CW_W-1:1], ^cand[CW_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FX_IDLE;
      w_q    <= '0;
      i_q    <= '0;
      j_q    <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      cw_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        FX_IDLE: if (load_i) begin
          w_q  <= word_i;
          st_q <= FX_CHK;
        end
        FX_CHK, FX_ONE, FX_TWO: begin
          if (hit) begin
            st_q   <= FX_IDLE;
            done_q <= 1'b1;
            ok_q   <= 1'b1;
            cw_q   <= fixed_cw;
          end else if (st_q == FX_CHK) begin
            st_q <= FX_ONE;
            i_q  <= POS_W'(1);
          end else if (st_q == FX_ONE) begin
            if (i_q == POS_LAST) begin
              st_q <= FX_TWO;
              i_q  <= POS_W'(1);
              j_q  <= POS_W'(2);
            end else begin
              i_q <= i_q + POS_W'(1);
            end
          end else if (j_q == POS_LAST) begin
            if (i_q == POS_PEN) begin
              st_q   <= FX_IDLE;
              done_q <= 1'b1;
              ok_q   <= 1'b0;
              cw_q   <= w_q;
            end else begin
              i_q <= i_q + POS_W'(1);
              j_q <= i_q + POS_W'(2);
            end
          end else begin
            j_q <= j_q + POS_W'(1);
          end
        end
        default: st_q <= FX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;
  assign cw_o   = cw_q;

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> st_q == FX_IDLE);  // R12
  AST_OK_IS_CODEWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (bch_syn(cw_o) == '0 && ^cw_o == 1'b0));  // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
endmodule

// File: rtl/pgr_framer.sv
module pgr_framer
  import pgr_pkg::*;
#(
  parameter int FRAMES = 8,
  localparam int SLOTS  = 2 * FRAMES,
  localparam int SLOT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic              restart_i,
  input  logic              fail_i,
  output logic              load_o,
  output logic [CW_W-1:0]   word_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              sync_o
);
  localparam int BC_W = $clog2(CW_W);
  localparam logic [BC_W-1:0]   BC_LAST   = BC_W'(CW_W-1);
  localparam logic [SLOT_W-1:0] SLOT_SYNC = SLOT_W'(SLOTS);

  fr_st_e            st_q;
  logic [CW_W-1:0]   sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [SLOT_W-1:0] slot_q;
  logic              word_end;

  assign word_o   = {sh_q[CW_W-2:0], bit_i};
  assign word_end = bit_vld_i && (bc_q == BC_LAST);
  assign load_o   = (st_q == FR_LOCK) && word_end && (slot_q < SLOT_SYNC);
  assign slot_o   = slot_q;
  assign sync_o   = (st_q == FR_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_HUNT;
      sh_q   <= '0;
      bc_q   <= '0;
      slot_q <= '0;
    end else if (fail_i) begin
      st_q <= FR_HALT;
    end else begin
      case (st_q)
        FR_HUNT: if (bit_vld_i) begin
          sh_q <= word_o;
          if (word_o == SYNC_CW) begin
            st_q   <= FR_LOCK;
            bc_q   <= '0;
            slot_q <= '0;
          end
        end
        FR_LOCK: if (bit_vld_i) begin
          sh_q <= word_o;
          bc_q <= bc_q + BC_W'(1);
          if (word_end) begin
            if (slot_q == SLOT_SYNC) begin
              if (word_o == SYNC_CW) slot_q <= '0;
              else                   st_q   <= FR_HUNT;
            end else begin
              slot_q <= slot_q + SLOT_W'(1);
            end
          end
        end
        FR_HALT: if (restart_i) begin
          st_q <= FR_HUNT;
          sh_q <= '0;
        end
        default: st_q <= FR_HUNT;
      endcase
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_HALT && !restart_i) |=> st_q == FR_HALT);  // R2
  AST_RESTART_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_HALT && restart_i && !fail_i) |=> st_q == FR_HUNT);  // R3
  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_SYNC);  // R4
endmodule

// File: rtl/pgr_route.sv
module pgr_route
  import pgr_pkg::*;
#(
  parameter int FRAMES = 8,
  localparam int SLOT_W = $clog2(2 * FRAMES + 1),
  localparam int FR_W   = $clog2(FRAMES),
  localparam int INFO_W = 20,
  localparam int FUNC_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [SLOT_W-1:0]      slot_i,
  input  logic                   sync_i,
  input  logic                   done_i,
  input  logic                   ok_i,
  input  logic [CW_W-1:0]        cw_i,
  output logic [CW_W-1:0]        cw_o,
  output logic                   cw_vld_o,
  output logic                   addr_cw_o,
  output logic [FR_W+FUNC_W-1:0] rx_addr_o,
  output logic [INFO_W-1:0]      rx_msg_o,
  output logic                   msg_vld_o,
  output logic [NSTICKY-1:0]     set_o
);
  logic [FR_W-1:0] frame_q;
  logic            act_q, good, bad, is_idle, is_msg, is_adr, take_msg;

  assign good     = done_i && ok_i;
  assign bad      = done_i && !ok_i;
  assign is_idle  = (cw_i == IDLE_CW);
  assign is_msg   = cw_i[CW_W-1];
  assign is_adr   = !cw_i[CW_W-1] && !is_idle;
  assign take_msg = good && is_msg && act_q;

  assign cw_o      = cw_i;
  assign cw_vld_o  = good;
  assign addr_cw_o = good && is_adr;

  always_comb begin
    set_o         = '0;
    set_o[FL_ADR] = good && is_adr;
    set_o[FL_BEG] = good && is_adr && !act_q;
    set_o[FL_MSG] = take_msg;
    set_o[FL_END] = good && is_idle && act_q;
    set_o[FL_ERR] = bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= '0;
      act_q     <= 1'b0;
      rx_addr_o <= '0;
      rx_msg_o  <= '0;
      msg_vld_o <= 1'b0;
    end else begin
      if (load_i) frame_q <= slot_i[FR_W:1];
      if (!sync_i || bad)            act_q <= 1'b0;
      else if (good && is_adr)       act_q <= 1'b1;
      else if (good && is_idle)      act_q <= 1'b0;
      if (good && is_adr) rx_addr_o <= {frame_q, cw_i[11+FUNC_W-1:11]};
      if (take_msg) rx_msg_o <= cw_i[CW_W-2:CW_W-1-INFO_W];
      if (bad)           msg_vld_o <= 1'b0;
      else if (take_msg) msg_vld_o <= 1'b1;
    end
  end

  AST_BAD_DROPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !msg_vld_o);  // R2
  AST_MSG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_msg |=> $stable(rx_msg_o));  // R8
endmodule

// File: rtl/pgr_flags.sv
module pgr_flags
  import pgr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSTICKY-1:0] set_i,
  input  logic               sync_i,
  input  logic [NFLAG-1:0]   clr_i,
  input  logic [NSTICKY-1:0] en_i,
  output logic [NFLAG-1:0]   flags_o,
  output logic               irq_o
);
  logic [NSTICKY-1:0] fl;

  for (genvar k = 0; k < NSTICKY; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[k] | (q & ~clr_i[k]);  // set wins
    end
    assign fl[k] = q;

    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fl[k] && !clr_i[k]) |=> fl[k]);  // R10
    AST_FLAG_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> fl[k]);  // R10
  end

  assign flags_o = {sync_i, fl};
  assign irq_o   = |(fl & en_i);
endmodule

// File: rtl/pgr_rx.sv
module pgr_rx
  import pgr_pkg::*;
#(
  parameter int FRAMES = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         bit_vld_i,
  input  logic         restart_i,
  input  logic [5:0]   flag_clr_i,
  input  logic [4:0]   irq_en_i,
  output logic [31:0]  cw_o,
  output logic         cw_vld_o,
  output logic         addr_cw_o,
  output logic [4:0]   rx_addr_o,
  output logic [19:0]  rx_msg_o,
  output logic         msg_vld_o,
  output logic [5:0]   flags_o,
  output logic         irq_o
);
  localparam int SLOT_W = $clog2(2 * FRAMES + 1);

  logic              load, sync, done, ok;
  logic [CW_W-1:0]   word, fix_cw;
  logic [SLOT_W-1:0] slot;
  logic [NSTICKY-1:0] set;

  pgr_framer #(.FRAMES(FRAMES)) u_framer (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i, .restart_i,
    .fail_i (done && !ok),
    .load_o (load),
    .word_o (word),
    .slot_o (slot),
    .sync_o (sync)
  );

  pgr_bch_fix u_fix (
    .clk_i, .rst_ni,
    .load_i (load),
    .word_i (word),
    .done_o (done),
    .ok_o   (ok),
    .cw_o   (fix_cw)
  );

  pgr_route #(.FRAMES(FRAMES)) u_route (
    .clk_i, .rst_ni,
    .load_i  (load),
    .slot_i  (slot),
    .sync_i  (sync),
    .done_i  (done),
    .ok_i    (ok),
    .cw_i    (fix_cw),
    .cw_o, .cw_vld_o, .addr_cw_o, .rx_addr_o, .rx_msg_o, .msg_vld_o,
    .set_o   (set)
  );

  pgr_flags u_flags (
    .clk_i, .rst_ni,
    .set_i   (set),
    .sync_i  (sync),
    .clr_i   (flag_clr_i),
    .en_i    (irq_en_i),
    .flags_o,
    .irq_o
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|flags_o[4:0]));  // R11
  AST_ERR_DROPS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !ok) |=> !flags_o[FL_SYNC]);  // R2
endmodule

// File: tb/pgr_rx_tb_top.sv
module pgr_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_GAP    = 20;
  localparam int SETTLE     = 600;
  localparam int WDOG       = 150000;
  localparam logic [31:0] SYNC = 32'h7CD215D8;
  localparam logic [31:0] IDLE = 32'h7A89C197;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_in = 1'b0, bit_vld = 1'b0, restart = 1'b0;
  logic [5:0] flag_clr = '0;
  logic [4:0] irq_en = '0;
  logic [31:0] cw;
  logic cw_vld, addr_cw, msg_vld, irq;
  logic [4:0] rx_addr;
  logic [19:0] rx_msg;
  logic [5:0] flags;

  int vectors = 0, miscompares = 0;
  int log_n = 0, addr_n = 0;
  logic [31:0] log_q [64];
  bit finished = 1'b0;

  pgr_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(bit_vld),
    .restart_i(restart), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .cw_o(cw), .cw_vld_o(cw_vld), .addr_cw_o(addr_cw), .rx_addr_o(rx_addr),
    .rx_msg_o(rx_msg), .msg_vld_o(msg_vld), .flags_o(flags), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cw_vld) begin
      if (log_n < 64) log_q[log_n] = cw;
      log_n++;
    end
    if (addr_cw) addr_n++;
  end

  function automatic logic [9:0] rem_of(input logic [30:0] v);
    logic [30:0] t = v;
    for (int d = 30; d >= 10; d--)
      if (t[d]) t = t ^ (31'(11'h769) << (d - 10));
    return t[9:0];
  endfunction

  function automatic logic [31:0] encode(input logic [20:0] info);
    logic [30:0] c = {info, rem_of({info, 10'b0})};
    return {c, ^c};
  endfunction

  function automatic bit fixable(input logic [31:0] w);
    if (rem_of(w[31:1]) == 0) return 1'b1;
    for (int i = 1; i < 32; i++) begin
      logic [31:0] a = w ^ (32'd1 << i);
      if (rem_of(a[31:1]) == 0) return 1'b1;
      for (int j = i + 1; j < 32; j++) begin
        logic [31:0] b = a ^ (32'd1 << j);
        if (rem_of(b[31:1]) == 0) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] corrupt(input logic [31:0] w, input int n, input int lo);
    logic [31:0] m = '0;
    while ($countones(m) < n) m = m | (32'd1 << $urandom_range(31, lo));
    return w ^ m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
    repeat (BIT_GAP - 2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 31; k >= 0; k--) send_bit(w[k]);
  endtask

  task automatic pulse_clr(input logic [5:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] e [16];
    logic [19:0] m5, em;
    logic [4:0] ea;
    logic [1:0] fn;
    logic [31:0] w, b;
    int base;
    bit act;
    void'($urandom(32'd2024));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset flags", 32'(flags), 32'h0);
    chk("R11 reset irq", 32'(irq), 32'h0);
    chk("R8 reset msg valid", 32'(msg_vld), 32'h0);

    // search with odd alignment, then lock
    for (int k = 0; k < int'($urandom_range(40, 3)); k++) send_bit(1'b0);
    send_word(SYNC);
    chk("R4 sync acquired", 32'(flags[5]), 32'h1);
    pulse_clr(6'b100000);
    chk("R10 sync not clearable", 32'(flags[5]), 32'h1);

    // batch 1: directed
    fn = 2'($urandom_range(3, 0));
    m5 = 20'($urandom);
    e[0] = IDLE; e[1] = IDLE;
    e[2] = encode({1'b0, 18'($urandom), fn});
    e[3] = encode({1'b1, 20'($urandom)});
    e[4] = encode({1'b1, 20'($urandom)});
    e[5] = encode({1'b1, m5});
    e[6] = IDLE;
    e[7] = encode({1'b1, 20'($urandom)});
    for (int s = 8; s < 16; s++) e[s] = IDLE;
    base = log_n;
    send_word(e[0]);
    send_word(corrupt(e[1], 1, 0));
    send_word(corrupt(e[2], 1, 1));
    send_word(corrupt(e[3], 2, 1));
    send_word(e[4]);
    send_word(corrupt(e[5], int'($urandom_range(2, 0)), 0));
    send_word(corrupt(e[6], 2, 0));
    send_word(corrupt(e[7], 1, 0));
    for (int s = 8; s < 16; s++) send_word(corrupt(e[s], int'($urandom_range(2, 0)), 0));
    send_word(SYNC);
    chk("R12 batch1 count", 32'(log_n - base), 32'd16);
    for (int s = 0; s < 16; s++) chk("R1 batch1 codeword", log_q[base + s], e[s]);
    chk("R5 sync kept", 32'(flags[5]), 32'h1);
    chk("R7 addr flag", 32'(flags[0]), 32'h1);
    chk("R8 msg flag", 32'(flags[1]), 32'h1);
    chk("R6 begin flag", 32'(flags[2]), 32'h1);
    chk("R9 end flag", 32'(flags[3]), 32'h1);
    chk("R7 rx_addr frame/func", 32'(rx_addr), 32'({3'd1, fn}));
    chk("R8 stray msg ignored", 32'(rx_msg), 32'(m5));
    chk("R8 msg valid", 32'(msg_vld), 32'h1);
    chk("R7 addr strobes", 32'(addr_n), 32'd1);

    // batch 2: random, then broken sync slot
    act = 1'b0; ea = {3'd1, fn}; em = m5; base = log_n;
    for (int s = 0; s < 16; s++) begin
      if ($urandom_range(1, 0) == 1) begin
        logic [1:0] f = 2'($urandom_range(3, 0));
        e[s] = encode({1'b0, 18'($urandom), f});
        act = 1'b1; ea = {3'(s >> 1), f};
      end else begin
        logic [19:0] mm = 20'($urandom);
        e[s] = encode({1'b1, mm});
        if (act) em = mm;
      end
      send_word(corrupt(e[s], int'($urandom_range(2, 0)), 0));
    end
    send_word(32'h0);
    chk("R5 sync lost", 32'(flags[5]), 32'h0);
    chk("R12 batch2 count", 32'(log_n - base), 32'd16);
    for (int s = 0; s < 16; s++) chk("R1 batch2 codeword", log_q[base + s], e[s]);
    chk("R7 batch2 rx_addr", 32'(rx_addr), 32'(ea));
    chk("R8 batch2 rx_msg", 32'(rx_msg), 32'(em));
    base = log_n;
    send_word(encode({1'b0, 20'($urandom)}));
    settle();
    chk("R5 no decode in search", 32'(log_n - base), 32'd0);

    // uncorrectable word
    send_word(SYNC);
    chk("R4 relock", 32'(flags[5]), 32'h1);
    do begin
      w = encode({1'b0, 20'($urandom)});
      b = corrupt(w, 3, 1);
    end while (fixable(b));
    base = log_n;
    send_word(b);
    settle();
    chk("R2 error flag", 32'(flags[4]), 32'h1);
    chk("R2 msg invalid", 32'(msg_vld), 32'h0);
    chk("R2 sync dropped", 32'(flags[5]), 32'h0);
    chk("R2 no emit", 32'(log_n - base), 32'd0);
    send_word(SYNC);
    send_word(encode({1'b0, 20'($urandom)}));
    settle();
    chk("R2 frozen sync", 32'(flags[5]), 32'h0);
    chk("R2 frozen no emit", 32'(log_n - base), 32'd0);

    // restart
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    send_word(SYNC);
    chk("R3 lock after restart", 32'(flags[5]), 32'h1);
    fn = 2'($urandom_range(3, 0));
    w = encode({1'b0, 18'($urandom), fn});
    send_word(corrupt(w, 1, 0));
    settle();
    chk("R3 decode after restart", 32'(log_n - base), 32'd1);
    chk("R3 codeword after restart", log_q[base], w);
    chk("R7 slot0 frame", 32'(rx_addr), 32'({3'd0, fn}));

    // sticky flags, clear mask, interrupt
    chk("R10 all sticky", 32'(flags), 32'h3F);
    @(negedge clk); irq_en = 5'b00000;
    @(negedge clk);
    chk("R11 irq masked", 32'(irq), 32'h0);
    irq_en = 5'b00100;
    @(negedge clk);
    chk("R11 irq enabled", 32'(irq), 32'h1);
    pulse_clr(6'b000100);
    chk("R10 single clear", 32'(flags), 32'h3B);
    chk("R11 irq after clear", 32'(irq), 32'h0);
    irq_en = 5'b10000;
    @(negedge clk);
    chk("R11 err irq", 32'(irq), 32'h1);
    pulse_clr(6'b111111);
    chk("R10 clear all", 32'(flags), 32'h20);
    chk("R11 irq none", 32'(irq), 32'h0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule